// File: doc/BRIEF.md
# Scalar Memory Outstanding-Request Counter

This block keeps a running count of one wavefront's scalar memory requests that have issued but not yet returned. Each accepted request adds a weight to the count: 1 for a request that reads one dword, 2 for any wider request, which includes the 64-bit timer reads. Each completion removes the weight of the request it finishes. Completions can come back in any order. A wait for a nonzero count therefore only shows that some requests have returned. A wait for zero is the only way to be sure that one particular result, including a timer value, has landed.

The sequencer presents one instruction slot per clock. That slot can carry a request issue, a wait with a threshold, or a descriptor write. A completion from memory can arrive in any cycle alongside the slot. The single `stall` output holds the slot in three cases: a wait whose threshold is still below the count, a request that would push the count past its maximum, or a buffer-form request arriving too soon after a descriptor write. A completion that finds nothing outstanding sets a sticky error flag.

Top module: `smem_wait_ctr`

## Requirements
- R1: After reset the count is 0, the error flag is low, a wait with threshold 0 does not stall, and a buffer-form request is not held by the descriptor guard.
- R2: An accepted request with `iss_dwords` of 0 or 1 raises the count by 1.
- R3: An accepted request with `iss_dwords` of 2 or more raises the count by 2; a 64-bit timer read is issued with `iss_dwords` = 2.
- R4: A completion lowers the count by 2 when `cpl_wide` is 1 and by 1 when it is 0.
- R5: An accepted request and a completion in the same cycle both take effect in that cycle's count update.
- R6: `stall` is high while `wait_valid` is high and the count is above `wait_thresh`. It drops in the first cycle after the clock edge at which the count reaches the threshold or less.
- R7: A request is stalled, and leaves the count unchanged, when adding its weight would take the count above 15 (the maximum of the 4-bit count). A request that brings the count to exactly 15 is accepted.
- R8: A completion whose weight exceeds the count plus any weight issued in the same cycle sets `underflow_err`, which stays high until reset. The count then becomes 0.
- R9: A buffer-form request (`iss_buf` = 1) in the slot right after a `desc_wr` slot is stalled for that one slot and is accepted in the slot after it.
- R10: If one slot, idle or holding another instruction, separates `desc_wr` from a buffer-form request, that request is not stalled. A request that is not buffer-form is never held by the descriptor guard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Slot holds a scalar memory request |
| iss_dwords | input | 5 | Number of dwords the request reads or writes |
| iss_buf | input | 1 | Request uses a buffer descriptor |
| cpl_valid | input | 1 | A request completed this cycle |
| cpl_wide | input | 1 | Completion weight is 2 (1 when low) |
| wait_valid | input | 1 | Slot holds a wait instruction |
| wait_thresh | input | 4 | Count at or below which the wait releases |
| desc_wr | input | 1 | Slot writes the third dword of a buffer descriptor |
| stall | output | 1 | Hold the current slot |
| underflow_err | output | 1 | Sticky flag for a completion with nothing left to retire |

## Verification
The bench reads the count back through the wait path. It sweeps thresholds and records the lowest one that does not stall. This catches a weight mix-up (wide requests counted as 1, timer reads as 1), which would release waits too early. The bench checks that a wait stays held through the clock edge where the last needed completion arrives, and that it releases on the next slot; a comparator on the next count would let a consumer read too soon. At the top of the range it checks that a request reaching exactly 15 goes through and that a request past 15 is held with the count unchanged; a wrapping counter would read as nearly empty. For the descriptor guard it checks a buffer request right after the write, after an idle slot, and after another request, so that a guard that is too eager or missing shows up.

// File: rtl/smem_wait_pkg.sv
package smem_wait_pkg;

  // Weight a request contributes to the outstanding count.
  function automatic logic [1:0] req_weight(input int unsigned dwords);
    return (dwords <= 1) ? 2'd1 : 2'd2;
  endfunction

  // Weight a completion removes from the outstanding count.
  function automatic logic [1:0] cpl_weight(input logic wide);
    return wide ? 2'd2 : 2'd1;
  endfunction

  // True when adding w to cnt stays within maxv.
  function automatic logic has_room(input int unsigned cnt, input int unsigned w,
                                    input int unsigned maxv);
    return (cnt + w) <= maxv;
  endfunction

endpackage

// File: rtl/smem_cnt_core.sv
module smem_cnt_core #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       inc_w,
  input  logic [1:0]       dec_w,
  output logic [CNT_W-1:0] cnt_q,
  output logic             under_now,
  output logic             err_q
);
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    sum       = {1'b0, cnt_q} + {{(CNT_W-1){1'b0}}, inc_w};
    under_now = {{(CNT_W-1){1'b0}}, dec_w} > sum;
    if (under_now) cnt_d = '0;
    else           cnt_d = CNT_W'(sum - {{(CNT_W-1){1'b0}}, dec_w});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_q | under_now;
    end
  end
endmodule

// File: rtl/smem_wait_eval.sv
module smem_wait_eval #(
  parameter int CNT_W = 4
) (
  input  logic             wait_valid,
  input  logic [CNT_W-1:0] wait_thresh,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             wait_hold
);
  assign wait_hold = wait_valid && (cnt_q > wait_thresh);
endmodule

// File: rtl/smem_desc_guard.sv
module smem_desc_guard #(
  parameter int GAP_SLOTS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic desc_wr,
  input  logic iss_valid,
  input  logic iss_buf,
  output logic hazard,
  output logic desc_hold
);
  logic [GAP_SLOTS-1:0] hist_q;

  generate
    if (GAP_SLOTS == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= desc_wr;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[GAP_SLOTS-2:0], desc_wr};
      end
    end
  endgenerate

  assign hazard    = |hist_q;
  assign desc_hold = hazard & iss_valid & iss_buf;
endmodule

// File: rtl/smem_wait_ctr.sv
module smem_wait_ctr
  import smem_wait_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int DW_W      = 5,
  parameter int GAP_SLOTS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [DW_W-1:0]  iss_dwords,
  input  logic             iss_buf,
  input  logic             cpl_valid,
  input  logic             cpl_wide,
  input  logic             wait_valid,
  input  logic [CNT_W-1:0] wait_thresh,
  input  logic             desc_wr,
  output logic             stall,
  output logic             underflow_err
);
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       req_w;
  logic [1:0]       inc_w;
  logic [1:0]       dec_w;
  logic             room_ok;
  logic             full_hold;
  logic             wait_hold;
  logic             desc_hold;
  logic             hazard;
  logic             iss_fire;
  logic             under_now;
  logic             err_q;

  assign req_w     = req_weight(int'(iss_dwords));
  assign room_ok   = has_room(int'(cnt_q), int'(req_w), CNT_MAX);
  assign full_hold = iss_valid & ~room_ok;
  assign stall     = wait_hold | full_hold | desc_hold;
  assign iss_fire  = iss_valid & ~stall;
  assign inc_w     = iss_fire ? req_w : 2'd0;
  assign dec_w     = cpl_valid ? cpl_weight(cpl_wide) : 2'd0;
  assign underflow_err = err_q;

  smem_cnt_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_w     (inc_w),
    .dec_w     (dec_w),
    .cnt_q     (cnt_q),
    .under_now (under_now),
    .err_q     (err_q)
  );

  smem_wait_eval #(.CNT_W(CNT_W)) u_wait (
    .wait_valid  (wait_valid),
    .wait_thresh (wait_thresh),
    .cnt_q       (cnt_q),
    .wait_hold   (wait_hold)
  );

  smem_desc_guard #(.GAP_SLOTS(GAP_SLOTS)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .desc_wr   (desc_wr),
    .iss_valid (iss_valid),
    .iss_buf   (iss_buf),
    .hazard    (hazard),
    .desc_hold (desc_hold)
  );
endmodule

// File: rtl/smem_wait_ctr_sva.sv
module smem_wait_ctr_sva #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall,
  input logic             underflow_err,
  input logic [CNT_W-1:0] cnt_q,
  input logic             wait_valid,
  input logic [CNT_W-1:0] wait_thresh,
  input logic             iss_valid,
  input logic             iss_buf,
  input logic             iss_fire,
  input logic             cpl_valid,
  input logic [1:0]       inc_w,
  input logic [1:0]       dec_w,
  input logic [1:0]       req_w,
  input logic             hazard
);
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_valid && (cnt_q > wait_thresh) |-> stall);

  p_wait_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_valid && (cnt_q <= wait_thresh) && !iss_valid |-> !stall);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && ((32'(cnt_q) + 32'(req_w)) > CNT_MAX) |-> stall);

  p_issue_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire && !cpl_valid |=> cnt_q == ($past(cnt_q) + CNT_W'($past(inc_w))));

  p_cpl_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !iss_valid && (cnt_q >= CNT_W'(dec_w))
    |=> cnt_q == ($past(cnt_q) - CNT_W'($past(dec_w))));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err);

  p_desc_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hazard && iss_valid && iss_buf |-> stall);
endmodule

bind smem_wait_ctr smem_wait_ctr_sva #(.CNT_W(CNT_W)) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .stall         (stall),
  .underflow_err (underflow_err),
  .cnt_q         (cnt_q),
  .wait_valid    (wait_valid),
  .wait_thresh   (wait_thresh),
  .iss_valid     (iss_valid),
  .iss_buf       (iss_buf),
  .iss_fire      (iss_fire),
  .cpl_valid     (cpl_valid),
  .inc_w         (inc_w),
  .dec_w         (dec_w),
  .req_w         (req_w),
  .hazard        (hazard)
);

// File: tb/smem_wait_ctr_tb.sv
module smem_wait_ctr_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iss_valid = 1'b0;
  logic [4:0] iss_dwords = '0;
  logic       iss_buf = 1'b0;
  logic       cpl_valid = 1'b0;
  logic       cpl_wide = 1'b0;
  logic       wait_valid = 1'b0;
  logic [3:0] wait_thresh = '0;
  logic       desc_wr = 1'b0;
  logic       stall;
  logic       underflow_err;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  smem_wait_ctr u_dut (
    .clk (clk), .rst_n (rst_n),
    .iss_valid (iss_valid), .iss_dwords (iss_dwords), .iss_buf (iss_buf),
    .cpl_valid (cpl_valid), .cpl_wide (cpl_wide),
    .wait_valid (wait_valid), .wait_thresh (wait_thresh),
    .desc_wr (desc_wr),
    .stall (stall), .underflow_err (underflow_err)
  );

  task automatic chk(input int act, input int exp, input string tag);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One instruction slot; exp_stall < 0 skips the stall check.
  task automatic slot(input bit iv, input int dw, input bit bf, input bit cv,
                      input bit cw, input bit wv, input int th, input bit dwr,
                      input int exp_stall, input string tag);
    @(negedge clk);
    iss_valid = iv; iss_dwords = 5'(dw); iss_buf = bf;
    cpl_valid = cv; cpl_wide = cw;
    wait_valid = wv; wait_thresh = 4'(th); desc_wr = dwr;
    #5;
    if (exp_stall >= 0) chk(int'(stall), exp_stall, tag);
    @(posedge clk);
    #1;
    iss_valid = 0; iss_dwords = '0; iss_buf = 0; cpl_valid = 0; cpl_wide = 0;
    wait_valid = 0; wait_thresh = '0; desc_wr = 0;
  endtask

  // Count readback: lowest wait threshold that does not stall.
  task automatic probe(input int exp, input string tag);
    int found = -1;
    for (int t = 0; t < 16; t++) begin
      @(negedge clk);
      wait_valid = 1; wait_thresh = 4'(t);
      #5;
      if (!stall && found < 0) found = t;
      @(posedge clk);
      #1;
      wait_valid = 0;
    end
    chk(found, exp, tag);
  endtask

  task automatic issue(input int dw, input string tag);
    slot(1, dw, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic retire(input bit wide);
    slot(0, 0, 0, 1, wide, 0, 0, 0, -1, "drain");
  endtask

  task automatic t_reset;
    probe(0, "R1 count after reset");
    @(negedge clk);
    chk(int'(underflow_err), 0, "R1 error after reset");
    slot(0, 0, 0, 0, 0, 1, 0, 0, 0, "R1 wait zero free");
    slot(1, 1, 1, 0, 0, 0, 0, 0, 0, "R1 buffer request free");
    retire(0);
  endtask

  task automatic t_weights;
    issue(1, "R2 single dword");
    probe(1, "R2 count after single");
    issue(0, "R2 zero dword field");
    probe(2, "R2 count after zero field");
    issue(16, "R3 sixteen dwords");
    probe(4, "R3 count after wide");
    issue(2, "R3 timer read");
    probe(6, "R3 count after timer read");
    retire(1);
    probe(4, "R4 wide completion");
    retire(0);
    probe(3, "R4 narrow completion");
    retire(1); retire(0);
    probe(0, "R4 drained");
  endtask

  task automatic t_same_cycle;
    issue(1, "R5 setup");
    slot(1, 4, 0, 1, 0, 0, 0, 0, 0, "R5 issue with completion");
    probe(2, "R5 net count");
    slot(1, 1, 0, 1, 1, 0, 0, 0, 0, "R5 narrow issue wide completion");
    probe(1, "R5 net count 2");
    retire(0);
  endtask

  task automatic t_wait;
    issue(16, "R6 setup");
    issue(1, "R6 setup");
    slot(0, 0, 0, 1, 0, 1, 1, 0, 1, "R6 held at count 3");
    slot(0, 0, 0, 1, 0, 1, 1, 0, 1, "R6 held in completing cycle");
    slot(0, 0, 0, 0, 0, 1, 1, 0, 0, "R6 released next slot");
    slot(0, 0, 0, 0, 0, 1, 0, 0, 1, "R6 zero still held");
    retire(0);
    slot(0, 0, 0, 0, 0, 1, 0, 0, 0, "R6 zero released");
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 7; i++) issue(2, "R7 fill");
    slot(1, 2, 0, 0, 0, 0, 0, 0, 1, "R7 wide past max stalled");
    probe(14, "R7 count unchanged");
    slot(1, 1, 0, 0, 0, 0, 0, 0, 0, "R7 reach exactly 15");
    slot(1, 1, 0, 0, 0, 0, 0, 0, 1, "R7 single past max stalled");
    probe(15, "R7 count at max");
    for (int i = 0; i < 7; i++) retire(1);
    retire(0);
    probe(0, "R7 drained");
  endtask

  task automatic t_desc_guard;
    slot(0, 0, 0, 0, 0, 0, 0, 1, 0, "R9 descriptor write");
    slot(1, 1, 1, 0, 0, 0, 0, 0, 1, "R9 buffer request held");
    slot(1, 1, 1, 0, 0, 0, 0, 0, 0, "R9 buffer request accepted");
    probe(1, "R9 one request counted");
    slot(0, 0, 0, 0, 0, 0, 0, 1, 0, "R10 descriptor write");
    slot(1, 1, 0, 0, 0, 0, 0, 0, 0, "R10 other request not held");
    slot(1, 1, 1, 0, 0, 0, 0, 0, 0, "R10 buffer after gap");
    slot(0, 0, 0, 0, 0, 0, 0, 1, 0, "R10 descriptor write");
    slot(0, 0, 0, 0, 0, 0, 0, 0, -1, "R10 idle slot");
    slot(1, 1, 1, 0, 0, 0, 0, 0, 0, "R10 buffer after idle");
    probe(4, "R10 count");
    retire(1); retire(1);
  endtask

  task automatic t_underflow;
    probe(0, "R8 start empty");
    @(negedge clk);
    chk(int'(underflow_err), 0, "R8 no error yet");
    retire(0);
    @(negedge clk);
    chk(int'(underflow_err), 1, "R8 error set");
    probe(0, "R8 count clamped");
    issue(1, "R8 issue after error");
    probe(1, "R8 count resumes");
    @(negedge clk);
    chk(int'(underflow_err), 1, "R8 error sticky");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_weights();
    t_same_cycle();
    t_wait();
    t_saturate();
    t_desc_guard();
    t_underflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule